// File: doc/BRIEF.md
# Byte-Serial Near Branch Resolver

This block sits behind an instruction byte stream and works out where a near relative branch goes. It accepts one byte per cycle, starting at an instruction boundary, through a valid/ready handshake. It recognises two encodings. The first is a single opcode byte 0xE9 followed by a 32-bit displacement: an unconditional jump, five bytes long. The second is an escape byte 0x0F, then a condition byte, then a 32-bit displacement: a conditional jump, six bytes long. The displacement arrives least significant byte first and is signed. The branch condition is evaluated against four flag inputs: zero, sign, overflow and carry.

One cycle after the last displacement byte is accepted, the block presents a single-cycle result. The result holds a branch indication, a taken bit and the next instruction pointer. Any other opcode produces a single-cycle not-a-branch result, and the block then returns to idle. For not-a-branch results the reported pointer is the start address of the instruction, so the surrounding pipeline can pass that instruction on unchanged.

The controller is an enumerated state machine with five states:
- IDLE: waiting for a first byte.
- ESCAPED: the escape byte has been seen; waiting for the condition byte.
- COLLECT: gathering displacement bytes.
- RESOLVED: presenting a branch result.
- PASS: presenting a not-a-branch result.

The transitions are:
- IDLE goes to COLLECT on 0xE9, to ESCAPED on 0x0F, and to PASS on any other byte.
- ESCAPED goes to COLLECT on a listed condition byte, and to PASS on any other byte.
- COLLECT goes to RESOLVED when the final displacement byte is accepted.
- RESOLVED and PASS always return to IDLE after one cycle.

Top module: `branch_resolver`

## Requirements
- R1: First byte 0xE9 starts an unconditional jump. After its 4 displacement bytes the result has branch=1 and taken=1, and next pointer = start + 5 + displacement.
- R2: First byte 0x0F starts a 6-byte conditional jump. Its next pointer is start + 6 when not taken, and start + 6 + displacement when taken.
- R3: Displacement bytes are taken least significant first, and the displacement is a signed 32-bit value, so negative values branch backwards.
- R4: Condition byte 0x84 is taken when zero=1. Condition byte 0x85 is taken when zero=0.
- R5: The signed conditions are:
  - 0x8F is taken when zero=0 and sign equals overflow.
  - 0x8D is taken when sign equals overflow.
  - 0x8C is taken when sign differs from overflow.
  - 0x8E is taken when zero=1 or sign differs from overflow.
- R6: The unsigned conditions are:
  - 0x87 is taken when carry=0 and zero=0.
  - 0x83 is taken when carry=0.
  - 0x82 is taken when carry=1.
  - 0x86 is taken when carry=1 or zero=1.
- R7: Flags are sampled in the cycle the last displacement byte is accepted; flag values before or after that cycle have no effect. The result is valid for exactly the one following cycle, and valid stays low while the bytes are being collected.
- R8: A first byte other than 0xE9 or 0x0F gives a one-cycle result with branch=0, taken=0, and next pointer equal to the start address. The byte that follows is decoded as a new first byte.
- R9: 0x0F followed by a byte outside the listed condition set gives a one-cycle not-a-branch result, with the next pointer equal to the start address.
- R10: A byte is consumed only when in_valid and in_ready are both high. in_ready is low while a result is presented. Idle gaps in the stream do not change the result.
- R11: Synchronous active-high reset returns the block to IDLE and clears a partially gathered displacement. res_valid is low while reset is held and in the cycle after it.
- R12: start_ip is sampled only together with the first byte of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte is present |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Block can accept a byte |
| start_ip | input | ADDR_W | Address of the first byte of the instruction |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_cf | input | 1 | Carry flag |
| res_valid | output | 1 | One-cycle result strobe |
| res_branch | output | 1 | Result belongs to a recognised branch |
| res_taken | output | 1 | Branch is taken |
| res_next_ip | output | ADDR_W | Resolved next instruction pointer |

## Verification
The bench builds the block with its defaults: ADDR_W=32 and DISP_BYTES=4. With these values the pointer and the displacement have the same width, so signed wrap-around and backward branches show up exactly as they would on a 32-bit machine. The four-byte displacement window also lets a distinct value in each byte position expose any misordering of the byte assembly. Every condition byte is driven with flag sets on both sides of its predicate, including the zero/carry and sign-versus-overflow combinations that separate the signed and unsigned forms.

// File: rtl/brz_pkg.sv
package brz_pkg;

    localparam logic [7:0] OP_JMP_NEAR = 8'hE9;
    localparam logic [7:0] OP_ESCAPE   = 8'h0F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ESCAPED,
        ST_COLLECT,
        ST_RESOLVED,
        ST_PASS
    } state_e;

    typedef enum logic [3:0] {
        CC_ALWAYS,
        CC_EQ,
        CC_NE,
        CC_SGT,
        CC_SGE,
        CC_SLT,
        CC_SLE,
        CC_UGT,
        CC_UGE,
        CC_ULT,
        CC_ULE
    } cond_e;

    typedef struct packed {
        logic  hit;
        cond_e cond;
    } cond_dec_t;

    function automatic cond_dec_t decode_cond(input logic [7:0] b);
        cond_dec_t d;
        d.hit  = 1'b1;
        d.cond = CC_ALWAYS;
        case (b)
            8'h84:   d.cond = CC_EQ;
            8'h85:   d.cond = CC_NE;
            8'h8F:   d.cond = CC_SGT;
            8'h8D:   d.cond = CC_SGE;
            8'h8C:   d.cond = CC_SLT;
            8'h8E:   d.cond = CC_SLE;
            8'h87:   d.cond = CC_UGT;
            8'h83:   d.cond = CC_UGE;
            8'h82:   d.cond = CC_ULT;
            8'h86:   d.cond = CC_ULE;
            default: d.hit  = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/brz_cond.sv
module brz_cond
    import brz_pkg::*;
(
    input  cond_e cond,
    input  logic  zf,
    input  logic  sf,
    input  logic  of,
    input  logic  cf,
    output logic  ok
);

    logic lt_signed;
    assign lt_signed = sf ^ of;

    always_comb begin
        unique case (cond)
            CC_ALWAYS: ok = 1'b1;
            CC_EQ:     ok = zf;
            CC_NE:     ok = !zf;
            CC_SGT:    ok = !zf && !lt_signed;
            CC_SGE:    ok = !lt_signed;
            CC_SLT:    ok = lt_signed;
            CC_SLE:    ok = zf || lt_signed;
            CC_UGT:    ok = !cf && !zf;
            CC_UGE:    ok = !cf;
            CC_ULT:    ok = cf;
            CC_ULE:    ok = cf || zf;
            default:   ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/brz_disp.sv
module brz_disp #(
    parameter int DISP_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    shift_en,
    input  logic [7:0]              byte_in,
    output logic                    at_last,
    output logic [8*DISP_BYTES-1:0] disp_next
);

    localparam int DISP_W = 8 * DISP_BYTES;
    localparam int CNT_W  = $clog2(DISP_BYTES + 1);

    logic [DISP_W-1:0] disp_q;
    logic [CNT_W-1:0]  cnt_q;

    assign at_last = (cnt_q == CNT_W'(DISP_BYTES - 1));

    generate
        if (DISP_BYTES == 1) begin : g_one
            assign disp_next = byte_in;
        end else begin : g_many
            assign disp_next = {byte_in, disp_q[DISP_W-1:8]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            disp_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en) begin
            disp_q <= disp_next;
            cnt_q  <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import brz_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DISP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] start_ip,
    input  logic              flag_zf,
    input  logic              flag_sf,
    input  logic              flag_of,
    input  logic              flag_cf,
    output logic              res_valid,
    output logic              res_branch,
    output logic              res_taken,
    output logic [ADDR_W-1:0] res_next_ip
);

    localparam int DISP_W    = 8 * DISP_BYTES;
    localparam int LEN_SHORT = 1 + DISP_BYTES;
    localparam int LEN_LONG  = 2 + DISP_BYTES;

    state_e            state_q, state_d;
    cond_e             cond_q;
    logic              esc_q;
    logic              taken_q;
    logic [ADDR_W-1:0] ip_q;
    logic [ADDR_W-1:0] next_q;

    logic              accept;
    logic              disp_last;
    logic [DISP_W-1:0] disp_full;
    logic              cond_ok;
    cond_dec_t         dec;
    logic [ADDR_W-1:0] end_ip;
    logic [ADDR_W-1:0] disp_ext;

    assign accept   = in_valid && in_ready;
    assign dec      = decode_cond(in_byte);
    assign end_ip   = ip_q + (esc_q ? ADDR_W'(LEN_LONG) : ADDR_W'(LEN_SHORT));
    assign disp_ext = ADDR_W'($signed(disp_full));

    brz_disp #(.DISP_BYTES(DISP_BYTES)) u_disp (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept && (state_q == ST_IDLE)),
        .shift_en  (accept && (state_q == ST_COLLECT)),
        .byte_in   (in_byte),
        .at_last   (disp_last),
        .disp_next (disp_full)
    );

    brz_cond u_cond (
        .cond (cond_q),
        .zf   (flag_zf),
        .sf   (flag_sf),
        .of   (flag_of),
        .cf   (flag_cf),
        .ok   (cond_ok)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                if (in_byte == OP_JMP_NEAR)    state_d = ST_COLLECT;
                else if (in_byte == OP_ESCAPE) state_d = ST_ESCAPED;
                else                           state_d = ST_PASS;
            end
            ST_ESCAPED: if (accept) state_d = dec.hit ? ST_COLLECT : ST_PASS;
            ST_COLLECT: if (accept && disp_last) state_d = ST_RESOLVED;
            ST_RESOLVED: state_d = ST_IDLE;
            ST_PASS:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Instruction context and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ip_q    <= '0;
            next_q  <= '0;
            taken_q <= 1'b0;
            esc_q   <= 1'b0;
            cond_q  <= CC_ALWAYS;
        end else if (accept) begin
            unique case (state_q)
                ST_IDLE: begin
                    ip_q    <= start_ip;
                    next_q  <= start_ip;
                    esc_q   <= (in_byte == OP_ESCAPE);
                    cond_q  <= CC_ALWAYS;
                    taken_q <= 1'b0;
                end
                ST_ESCAPED: cond_q <= dec.cond;
                ST_COLLECT: if (disp_last) begin
                    taken_q <= cond_ok;
                    next_q  <= end_ip + (cond_ok ? disp_ext : '0);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready    = 1'b0;
        res_valid   = 1'b0;
        res_branch  = 1'b0;
        res_taken   = 1'b0;
        res_next_ip = '0;
        unique case (state_q)
            ST_IDLE, ST_ESCAPED, ST_COLLECT: in_ready = 1'b1;
            ST_RESOLVED: begin
                res_valid   = 1'b1;
                res_branch  = 1'b1;
                res_taken   = taken_q;
                res_next_ip = next_q;
            end
            ST_PASS: begin
                res_valid   = 1'b1;
                res_next_ip = next_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/brz_chk.sv
module brz_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic res_valid,
    input logic res_branch,
    input logic res_taken
);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R10
    ready_low_result_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !in_ready);

    // R8
    taken_needs_branch_chk: assert property (@(posedge clk) disable iff (rst)
        res_taken |-> (res_valid && res_branch));

    // R11
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_valid);

    // R10
    result_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid && in_ready));

endmodule

bind branch_resolver brz_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .res_valid  (res_valid),
    .res_branch (res_branch),
    .res_taken  (res_taken)
);

// File: tb/branch_resolver_test.sv
module branch_resolver_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic [31:0] start_ip = '0;
    logic        flag_zf = 1'b0, flag_sf = 1'b0, flag_of = 1'b0, flag_cf = 1'b0;
    logic        res_valid, res_branch, res_taken;
    logic [31:0] res_next_ip;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_resolver uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .start_ip(start_ip),
        .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of), .flag_cf(flag_cf),
        .res_valid(res_valid), .res_branch(res_branch), .res_taken(res_taken),
        .res_next_ip(res_next_ip)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // flags packed as {zf, sf, of, cf}
    task automatic set_flags(input logic [3:0] f);
        {flag_zf, flag_sf, flag_of, flag_cf} = f;
    endtask

    // called at a negedge; returns at the negedge after the byte is consumed
    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hA5;
    endtask

    task automatic check_result(input string tag, input logic br, input logic tk,
                                input logic [31:0] nip);
        check({tag, " valid"},  res_valid,   1'b1);
        check({tag, " branch"}, res_branch,  br);
        check({tag, " taken"},  res_taken,   tk);
        check({tag, " next"},   res_next_ip, nip);
        @(negedge clk);
        check({tag, " pulse ends"}, res_valid, 1'b0);
    endtask

    task automatic do_jump(input string tag, input logic [31:0] ip, input logic esc,
                           input logic [7:0] cc, input logic [31:0] disp,
                           input logic [3:0] f, input logic exp_taken, input int gap);
        logic [31:0] len;
        len = esc ? 32'd6 : 32'd5;
        set_flags(f);
        start_ip = ip;
        if (esc) begin
            put(8'h0F);
            start_ip = 32'hDEAD_0000;   // R12: must not be resampled
            put(cc);
        end else begin
            put(8'hE9);
            start_ip = 32'hDEAD_0000;
        end
        for (int i = 0; i < 4; i++) begin
            check({tag, " R7 no early valid"}, res_valid, 1'b0);
            repeat (gap) @(negedge clk);
            put(disp[8*i +: 8]);
        end
        set_flags(~f);                   // R7: later flags ignored
        check_result(tag, 1'b1, exp_taken, ip + len + (exp_taken ? disp : 32'd0));
    endtask

    task automatic t_reset;
        check("R11 valid in reset", res_valid, 1'b0);
        @(negedge clk); rst = 1'b0;
        check("R11 valid after reset", res_valid, 1'b0);
        check("R10 ready in idle", in_ready, 1'b1);
    endtask

    task automatic t_uncond;
        do_jump("R1 jmp +5", 32'h1, 1'b0, 8'h00, 32'd5, 4'b0000, 1'b1, 0);
        do_jump("R1 jmp flags set", 32'h40, 1'b0, 8'h00, 32'h20, 4'b1111, 1'b1, 0);
        do_jump("R3 backward", 32'h100, 1'b0, 8'h00, 32'hFFFF_FFFB, 4'b0000, 1'b1, 0);
        do_jump("R3 byte order", 32'h0, 1'b0, 8'h00, 32'h1234_5678, 4'b0000, 1'b1, 0);
    endtask

    task automatic t_zero_conds;
        do_jump("R2 R4 je taken",  32'h1, 1'b1, 8'h84, 32'd5, 4'b1000, 1'b1, 0);
        do_jump("R2 R4 je not",    32'h1, 1'b1, 8'h84, 32'd5, 4'b0000, 1'b0, 0);
        do_jump("R4 jne taken",    32'h1, 1'b1, 8'h85, 32'd5, 4'b0000, 1'b1, 0);
        do_jump("R4 jne not",      32'h1, 1'b1, 8'h85, 32'd5, 4'b1000, 1'b0, 0);
    endtask

    task automatic t_signed_conds;
        do_jump("R5 jg taken",   32'h1, 1'b1, 8'h8F, 32'd5, 4'b0000, 1'b1, 0);
        do_jump("R5 jg s!=o",    32'h1, 1'b1, 8'h8F, 32'd5, 4'b0100, 1'b0, 0);
        do_jump("R5 jg zero",    32'h1, 1'b1, 8'h8F, 32'd5, 4'b1000, 1'b0, 0);
        do_jump("R5 jge s=o=1",  32'h1, 1'b1, 8'h8D, 32'd5, 4'b0110, 1'b1, 0);
        do_jump("R5 jge not",    32'h1, 1'b1, 8'h8D, 32'd5, 4'b0100, 1'b0, 0);
        do_jump("R5 jl taken",   32'h1, 1'b1, 8'h8C, 32'd5, 4'b0010, 1'b1, 0);
        do_jump("R5 jl not",     32'h1, 1'b1, 8'h8C, 32'd5, 4'b0000, 1'b0, 0);
        do_jump("R5 jle zero",   32'h1, 1'b1, 8'h8E, 32'd5, 4'b1000, 1'b1, 0);
        do_jump("R5 jle less",   32'h1, 1'b1, 8'h8E, 32'd5, 4'b0100, 1'b1, 0);
        do_jump("R5 jle not",    32'h1, 1'b1, 8'h8E, 32'd5, 4'b0000, 1'b0, 0);
    endtask

    task automatic t_unsigned_conds;
        do_jump("R6 ja taken",   32'h1, 1'b1, 8'h87, 32'd5, 4'b0000, 1'b1, 0);
        do_jump("R6 ja zero",    32'h1, 1'b1, 8'h87, 32'd5, 4'b1000, 1'b0, 0);
        do_jump("R6 ja carry",   32'h1, 1'b1, 8'h87, 32'd5, 4'b0001, 1'b0, 0);
        do_jump("R6 jae taken",  32'h1, 1'b1, 8'h83, 32'd5, 4'b0110, 1'b1, 0);
        do_jump("R6 jae not",    32'h1, 1'b1, 8'h83, 32'd5, 4'b0001, 1'b0, 0);
        do_jump("R6 jb taken",   32'h1, 1'b1, 8'h82, 32'd5, 4'b0001, 1'b1, 0);
        do_jump("R6 jb not",     32'h1, 1'b1, 8'h82, 32'd5, 4'b0110, 1'b0, 0);
        do_jump("R6 jbe zero",   32'h1, 1'b1, 8'h86, 32'd5, 4'b1000, 1'b1, 0);
        do_jump("R6 jbe carry",  32'h1, 1'b1, 8'h86, 32'd5, 4'b0001, 1'b1, 0);
        do_jump("R6 jbe not",    32'h1, 1'b1, 8'h86, 32'd5, 4'b0110, 1'b0, 0);
    endtask

    task automatic t_flag_timing;
        // R7: flags true only during the final-byte accept cycle
        set_flags(4'b0000);
        start_ip = 32'h200;
        put(8'h0F); put(8'h84);
        put(8'h10); put(8'h00); put(8'h00);
        set_flags(4'b1000);
        put(8'h00);
        set_flags(4'b0000);
        check_result("R7 sample at last byte", 1'b1, 1'b1, 32'h200 + 32'd6 + 32'h10);
        // R7: flags true earlier but false at the final byte
        set_flags(4'b1000);
        start_ip = 32'h300;
        put(8'h0F); put(8'h84); put(8'h10); put(8'h00); put(8'h00);
        set_flags(4'b0000);
        put(8'h00);
        check_result("R7 early flags ignored", 1'b1, 1'b0, 32'h306);
    endtask

    task automatic t_gaps;
        do_jump("R10 gaps", 32'h1000, 1'b1, 8'h8C, 32'hFFFF_FF00, 4'b0100, 1'b1, 3);
    endtask

    task automatic t_not_branch;
        start_ip = 32'h50;
        put(8'h05);
        check("R10 ready low on result", in_ready, 1'b0);
        check_result("R8 other opcode", 1'b0, 1'b0, 32'h50);
        // next byte decoded as a fresh first byte, not as a displacement
        do_jump("R8 next decoded fresh", 32'h60, 1'b0, 8'h00, 32'd8, 4'b0000, 1'b1, 0);
        start_ip = 32'h70;
        put(8'h0F);
        put(8'h90);
        check_result("R9 unlisted escape", 1'b0, 1'b0, 32'h70);
        start_ip = 32'h80;
        put(8'h0F);
        put(8'hE9);
        check_result("R9 escape then jmp byte", 1'b0, 1'b0, 32'h80);
    endtask

    task automatic t_mid_reset;
        start_ip = 32'h400;
        put(8'hE9); put(8'hFF); put(8'hFF);
        rst = 1'b1;
        @(negedge clk);
        check("R11 valid during reset", res_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 idle after reset", in_ready, 1'b1);
        do_jump("R11 clean restart", 32'h500, 1'b0, 8'h00, 32'd3, 4'b0000, 1'b1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_uncond();
        t_zero_conds();
        t_signed_conds();
        t_unsigned_conds();
        t_flag_timing();
        t_gaps();
        t_not_branch();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule